// File: doc/BRIEF.md
# Infrared Link Interrupt Status Block

This block gathers single-cycle event pulses from an infrared serial link core and turns them into sticky status bits that a processor reads over a small 16-bit register port. There are two event groups, one for the slow asynchronous link speed and one for the medium and fast link speeds. Both groups use the same bit positions. Bits 8 and 9 carry a different meaning in each group. In the slow group they are a framing error and a receive timeout. In the fast group they are a CRC error and an abort detection.

Each group has a status register, a per-bit mask register and a write-one-to-clear register. A mode register holds the 2-bit transfer-mode field and three group-level block bits: one for the slow group, one for the fast group and one for a FIFO receive request line. Unmasked, unblocked status drives one interrupt output, which is registered.

Top module: `irda_evt_irq`

## Requirements
- R1: After reset, the mode register reads 0x0111, both mask registers read 0x8B80, both status registers read 0x0000, and `irq` is 0.
- R2: Event input index 0..4 maps to status bit 7 (transmit end), 8, 9, 11 (transfer-area overflow) and 15 (receive end). All other status and mask bits read 0, and the mode register keeps only bits 15:14, 8, 4 and 0.
- R3: A status bit is set one cycle after its event pulse and holds its value until it is cleared.
- R4: Writing a 1 to a bit of a group's clear register clears that status bit. Bits written 0 are unchanged. The clear register reads 0.
- R5: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: A mask bit at 1 keeps the matching status bit from raising `irq`. A mask bit at 0 lets it through.
- R7: Mode bit 0 blocks the slow group, mode bit 4 blocks the fast group and mode bit 8 blocks `fifo_rx_req`. A 0 in the bit lets the source through.
- R8: `irq` is registered. It rises on the clock edge after the edge that sets the pending status.
- R9: A status read returns the latched bits whatever the mask and mode settings are.
- R10: The transfer-mode field sits at mode bits 15:14 (00 slow, 11 medium, 10 fast). It is writable and read back, and it does not change interrupt behaviour.
- R11: A clear of one group leaves the other group's status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Register select: 0 mode, 1/2/3 slow status/mask/clear, 4/5/6 fast status/mask/clear |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, same cycle |
| sir_evt | input | 5 | Slow-group event pulses |
| mf_evt | input | 5 | Fast-group event pulses |
| fifo_rx_req | input | 1 | FIFO receive interrupt request, level |
| irq | output | 1 | Combined interrupt |

## Verification
A vector table drives events into each group under many combinations of per-bit mask and group-block bits. Each vector checks both `irq` and the raw status. This separates a per-bit mask failure from a group-gating failure, and it shows that a masked bit still latches. One vector mixes a masked and an unmasked bit in the same group, so an implementation that masks the whole group is caught. Directed cases then test:
- set-versus-clear collisions;
- partial clears and clears that reach across groups;
- writes of all ones into reserved bits;
- the FIFO request path;
- the one-cycle interrupt latency.

// File: rtl/irda_evt_irq.sv
module irda_evt_irq #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  input  logic [4:0]    sir_evt,
  input  logic [4:0]    mf_evt,
  input  logic          fifo_rx_req,
  output logic          irq
);
  localparam logic [15:0] EVT_BITS  = 16'h8B80;
  localparam logic [15:0] MODE_BITS = 16'hC111;
  localparam logic [15:0] MODE_RST  = 16'h0111;
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_SST  = AW'(1);
  localparam logic [AW-1:0] A_SMSK = AW'(2);
  localparam logic [AW-1:0] A_SCLR = AW'(3);
  localparam logic [AW-1:0] A_FST  = AW'(4);
  localparam logic [AW-1:0] A_FMSK = AW'(5);
  localparam logic [AW-1:0] A_FCLR = AW'(6);

  function automatic logic [15:0] spread(input logic [4:0] e);
    return {e[4], 3'b000, e[3], 1'b0, e[2], e[1], e[0], 7'b0000000};
  endfunction

  logic [15:0] mode_q, sir_stat, sir_mask, mf_stat, mf_mask;
  logic [15:0] sir_set, mf_set, sir_clr, mf_clr;
  logic        sir_req, mf_req, fifo_req, irq_q;

  assign sir_set = spread(sir_evt);
  assign mf_set  = spread(mf_evt);
  assign sir_clr = (wr_en && addr == A_SCLR) ? (wr_data & EVT_BITS) : 16'h0000;
  assign mf_clr  = (wr_en && addr == A_FCLR) ? (wr_data & EVT_BITS) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      sir_stat <= 16'h0000;
      mf_stat  <= 16'h0000;
      sir_mask <= EVT_BITS;
      mf_mask  <= EVT_BITS;
    end else begin
      sir_stat <= (sir_stat & ~sir_clr) | sir_set;
      mf_stat  <= (mf_stat & ~mf_clr) | mf_set;
      if (wr_en && addr == A_MODE) mode_q   <= wr_data & MODE_BITS;
      if (wr_en && addr == A_SMSK) sir_mask <= wr_data & EVT_BITS;
      if (wr_en && addr == A_FMSK) mf_mask  <= wr_data & EVT_BITS;
    end
  end

  assign sir_req  = (|(sir_stat & ~sir_mask)) & ~mode_q[0];
  assign mf_req   = (|(mf_stat & ~mf_mask)) & ~mode_q[4];
  assign fifo_req = fifo_rx_req & ~mode_q[8];

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= sir_req | mf_req | fifo_req;
  end
  assign irq = irq_q;

  always_comb begin
    case (addr)
      A_MODE:  rd_data = mode_q;
      A_SST:   rd_data = sir_stat;
      A_SMSK:  rd_data = sir_mask;
      A_FST:   rd_data = mf_stat;
      A_FMSK:  rd_data = mf_mask;
      default: rd_data = 16'h0000;
    endcase
  end
endmodule

// File: rtl/irda_evt_irq_chk.sv
module irda_evt_irq_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic [4:0]    sir_evt,
  input logic [4:0]    mf_evt,
  input logic [15:0]   sir_stat,
  input logic [15:0]   sir_mask,
  input logic [15:0]   mf_stat,
  input logic [15:0]   mode_q,
  input logic          irq
);
  localparam logic [AW-1:0] A_SCLR = AW'(3);

  // R5
  sir_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sir_evt[0] |=> sir_stat[7]);

  // R3
  sir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sir_stat[15] && !(wr_en && addr == A_SCLR && wr_data[15])) |=> sir_stat[15]);

  // R8
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(sir_stat & ~sir_mask)) && !mode_q[0]) |=> irq);

  // R7
  all_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && mode_q[4] && mode_q[8]) |=> !irq);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sir_stat | mf_stat) & ~16'h8B80) == 16'h0000);

  // R5
  mf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_evt[4] |=> mf_stat[15]);
endmodule

bind irda_evt_irq irda_evt_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .sir_evt(sir_evt), .mf_evt(mf_evt), .sir_stat(sir_stat), .sir_mask(sir_mask),
  .mf_stat(mf_stat), .mode_q(mode_q), .irq(irq)
);

// File: tb/sim_irda_evt_irq.sv
module sim_irda_evt_irq;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, fifo_rx_req = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wr_data = 16'h0000;
  logic [4:0] sir_evt = 5'd0, mf_evt = 5'd0;
  logic [15:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irda_evt_irq #(.AW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sir_evt(sir_evt), .mf_evt(mf_evt),
    .fifo_rx_req(fifo_rx_req), .irq(irq)
  );

  function automatic logic [15:0] spread(input logic [4:0] e);
    return {e[4], 3'b000, e[3], 1'b0, e[2], e[1], e[0], 7'b0000000};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rd_data;
  endtask

  task automatic pulse(input logic [4:0] se, input logic [4:0] me);
    @(negedge clk); sir_evt = se; mf_evt = me;
    @(negedge clk); sir_evt = 5'd0; mf_evt = 5'd0;
  endtask

  // {sir_mask, mf_mask, mode, sir_evt, mf_evt, irq}
  localparam logic [58:0] VEC [6] = '{
    {16'h0000, 16'h8B80, 16'h0110, 5'b00001, 5'b00000, 1'b1},
    {16'h0000, 16'h8B80, 16'h0111, 5'b00001, 5'b00000, 1'b0},
    {16'h0080, 16'h0000, 16'h0100, 5'b00001, 5'b00000, 1'b0},
    {16'h8B80, 16'h0000, 16'hC101, 5'b00000, 5'b10000, 1'b1},
    {16'h0000, 16'h0000, 16'h0110, 5'b00000, 5'b10000, 1'b0},
    {16'h0200, 16'h8B80, 16'h8110, 5'b01100, 5'b00000, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); chk("R1 mode", v, 16'h0111);
    rd(3'd2, v); chk("R1 sir mask", v, 16'h8B80);
    rd(3'd5, v); chk("R1 mf mask", v, 16'h8B80);
    rd(3'd1, v); chk("R1 sir stat", v, 16'h0000);
    rd(3'd4, v); chk("R1 mf stat", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    foreach (VEC[i]) begin
      wr(3'd3, 16'hFFFF); wr(3'd6, 16'hFFFF);
      wr(3'd2, VEC[i][58:43]); wr(3'd5, VEC[i][42:27]); wr(3'd0, VEC[i][26:11]);
      pulse(VEC[i][10:6], VEC[i][5:1]);
      @(negedge clk);
      // R6 R7 per-bit mask and group gating
      chk($sformatf("R6/R7 vec%0d irq", i), {15'd0, irq}, {15'd0, VEC[i][0]});
      // R9 raw status
      rd(3'd1, v); chk($sformatf("R9 vec%0d sir stat", i), v, spread(VEC[i][10:6]));
      rd(3'd4, v); chk($sformatf("R9 vec%0d mf stat", i), v, spread(VEC[i][5:1]));
    end

    // R10 mode field readback, R2 reserved bits
    wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R10 mode all ones", v, 16'hC111);
    wr(3'd0, 16'h8000); rd(3'd0, v); chk("R10 mode fast field", v, 16'h8000);
    wr(3'd2, 16'hFFFF); rd(3'd2, v); chk("R2 mask reserved", v, 16'h8B80);
    rd(3'd3, v); chk("R4 clear reads zero", v, 16'h0000);

    // R8 latency, R2 mapping
    wr(3'd3, 16'hFFFF); wr(3'd6, 16'hFFFF);
    wr(3'd2, 16'h0000); wr(3'd5, 16'h8B80); wr(3'd0, 16'h0110);
    pulse(5'b11111, 5'b00000);
    chk("R8 irq not yet", {15'd0, irq}, 16'h0000);
    rd(3'd1, v); chk("R2 R3 all events", v, 16'h8B80);
    @(negedge clk);
    chk("R8 irq one cycle later", {15'd0, irq}, 16'h0001);

    // R4 partial clear, R11 cross-group
    pulse(5'b00000, 5'b11111);
    wr(3'd3, 16'h0880); rd(3'd1, v); chk("R4 partial clear", v, 16'h8300);
    rd(3'd4, v); chk("R11 other group intact", v, 16'h8B80);
    wr(3'd6, 16'h8000); rd(3'd1, v); chk("R11 sir untouched", v, 16'h8300);
    rd(3'd4, v); chk("R4 mf bit15 cleared", v, 16'h0B80);

    // R5 set wins over clear
    @(negedge clk); sir_evt = 5'b00001; addr = 3'd3; wr_data = 16'h0080; wr_en = 1'b1;
    @(negedge clk); sir_evt = 5'd0; wr_en = 1'b0;
    rd(3'd1, v); chk("R5 set wins", v, 16'h8380);

    // R3 hold over time
    repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R3 hold", v, 16'h8380);

    // R7 FIFO source gating
    wr(3'd3, 16'hFFFF); wr(3'd6, 16'hFFFF); wr(3'd0, 16'h0111);
    @(negedge clk); fifo_rx_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 fifo blocked", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h0011);
    @(negedge clk);
    chk("R7 fifo open", {15'd0, irq}, 16'h0001);
    fifo_rx_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 fifo released", {15'd0, irq}, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule